// File: doc/BRIEF.md
# Transposed FIR Filter with a Shared Shift-and-Add Multiplier Graph

This block is a five-tap, fixed-coefficient FIR filter in transposed form. Every accepted input sample goes at once to all tap products. The products do not come from one multiplier per tap. A single shift-and-add graph driven by the sample builds them, and each intermediate sum in that graph is itself a needed product. The coefficient set is {5, 261, 341, 261, 5}. The graph forms 5x as (x<<2)+x, then 261x as (x<<8)+5x, then 341x as 261x+(5x<<4). That is three adders for all five taps, and the symmetric taps reuse the same values.

The products feed an adder chain. Registers sit between its adders, so the filtered value is the sum of the current product and the delayed partial sums. The chain advances only on cycles that carry a valid sample. The filter emits one output for each accepted sample, registered one clock later. The accumulator is wide enough that no input sequence can overflow it.

There is no control state machine: the only sequencing is the input-valid strobe, which enables the delay registers.

Top module: `fir_mcm_top`

## Requirements
- R1: While rst_n is low and after its release, out_valid is 0 and out_data is 0. All delay registers are cleared, so the first output after reset depends only on samples accepted after reset.
- R2: out_valid is high in exactly the cycle after each cycle in which in_valid is high, and low otherwise.
- R3: Each output equals 5*x[n] + 261*x[n-1] + 341*x[n-2] + 261*x[n-3] + 5*x[n-4]. Here x[n] is the sample accepted with it and x[n-1]..x[n-4] are the previously accepted samples (zero before the first).
- R4: A cycle with in_valid low changes neither out_data nor the delay registers, whatever in_data holds. The next valid output ignores that data.
- R5: A single sample of value 1 followed by zeros yields the outputs 5, 261, 341, 261, 5, 0 in that order.
- R6: in_data is a signed two's-complement value of DATA_W bits. out_data is signed with DATA_W+12 bits and never overflows: five samples of +2047 give 1787031 and five of -2048 give -1787904 at the default width.
- R7: The shared graph yields exactly 5x, 261x and 341x for every input value using only shifts, additions and subtractions. Taps 0 and 4 use 5x, taps 1 and 3 use 261x, and tap 2 uses 341x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | High when in_data carries a sample |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | High for one cycle per filtered value |
| out_data | output | DATA_W+12 | Signed filtered value |

## Verification
The hardest situation to reach from the ports is a gap in the sample stream while the delay chain holds partial sums. The chain must keep them untouched even though in_data carries large unrelated values. The stimulus inserts invalid cycles carrying garbage between valid samples, both in the fixed vector table and in a long randomized run. It checks that out_data holds through the gap and that the next valid output still matches a direct convolution of the accepted samples only. Full-scale runs of the extreme positive and negative input drive the accumulator to its bounds.

// File: rtl/fir_mcm_pkg.sv
package fir_mcm_pkg;

    // number of taps in the fixed filter
    localparam int TAPS      = 5;
    // magnitude bits of the largest coefficient (341 < 512)
    localparam int COEF_BITS = 9;
    // sum of all coefficients, used for output range bounds
    localparam int COEF_SUM  = 873;

    // intermediate values produced by the shared graph
    typedef enum logic [1:0] {
        FUND_X5   = 2'd0,
        FUND_X261 = 2'd1,
        FUND_X341 = 2'd2
    } fund_e;

    // which shared value feeds a given tap
    function automatic fund_e fund_of_tap(input int k);
        int m;
        m = (k > TAPS - 1 - k) ? TAPS - 1 - k : k;
        case (m)
            0:       return FUND_X5;
            1:       return FUND_X261;
            default: return FUND_X341;
        endcase
    endfunction

    // accumulator width: data bits + coefficient bits + growth of the tap sum
    function automatic int acc_width(input int data_w);
        return data_w + COEF_BITS + $clog2(TAPS);
    endfunction

endpackage

// File: rtl/fir_mcm_graph.sv
module fir_mcm_graph #(
    parameter int IN_W  = 12,
    parameter int OUT_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [IN_W-1:0]  x,
    output logic signed [OUT_W-1:0] f5,
    output logic signed [OUT_W-1:0] f261,
    output logic signed [OUT_W-1:0] f341
);

    logic signed [OUT_W-1:0] xe;

    always_comb begin
        xe   = OUT_W'(x);
        // 5x = 4x + x
        f5   = (xe <<< 2) + xe;
        // 261x = 256x + 5x
        f261 = (xe <<< 8) + f5;
        // 341x = 261x + 16*5x
        f341 = f261 + (f5 <<< 4);
    end

    // R7
    fund_x5_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f5 == xe * 5);
    // R7
    fund_x261_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f261 == xe * 261);
    // R7
    fund_x341_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f341 == xe * 341);

endmodule

// File: rtl/fir_mcm_chain.sv
module fir_mcm_chain #(
    parameter int TAPS  = 5,
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [ACC_W-1:0] prod [TAPS],
    output logic signed [ACC_W-1:0] head
);

    // delay registers between the adders; index 1 is nearest the output
    logic signed [ACC_W-1:0] dly_q [1:TAPS-1];

    for (genvar k = 1; k < TAPS; k++) begin : g_stage
        if (k == TAPS - 1) begin : g_last
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    dly_q[k] <= '0;
                else if (en)
                    dly_q[k] <= prod[k];
            end
        end else begin : g_mid
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    dly_q[k] <= '0;
                else if (en)
                    dly_q[k] <= prod[k] + dly_q[k+1];
            end
        end

        // R4
        stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> $stable(dly_q[k]));
    end

    assign head = prod[0] + dly_q[1];

endmodule

// File: rtl/fir_mcm_top.sv
module fir_mcm_top
    import fir_mcm_pkg::*;
#(
    parameter int DATA_W = 12,
    localparam int ACC_W = acc_width(DATA_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                    out_valid,
    output logic signed [ACC_W-1:0] out_data
);

    localparam longint MAX_OUT = ((longint'(1) <<< (DATA_W - 1)) - 1) * COEF_SUM;
    localparam longint MIN_OUT = -(longint'(1) <<< (DATA_W - 1)) * COEF_SUM;

    logic signed [ACC_W-1:0] f5;
    logic signed [ACC_W-1:0] f261;
    logic signed [ACC_W-1:0] f341;
    logic signed [ACC_W-1:0] prod [TAPS];
    logic signed [ACC_W-1:0] head;

    fir_mcm_graph #(
        .IN_W  (DATA_W),
        .OUT_W (ACC_W)
    ) i_graph (
        .clk   (clk),
        .rst_n (rst_n),
        .x     (in_data),
        .f5    (f5),
        .f261  (f261),
        .f341  (f341)
    );

    // route each shared value to the taps that use it
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        localparam fund_e SEL = fund_of_tap(k);
        always_comb begin
            unique case (SEL)
                FUND_X5:   prod[k] = f5;
                FUND_X261: prod[k] = f261;
                FUND_X341: prod[k] = f341;
                default:   prod[k] = '0;
            endcase
        end
    end

    fir_mcm_chain #(
        .TAPS  (TAPS),
        .ACC_W (ACC_W)
    ) i_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_valid),
        .prod  (prod),
        .head  (head)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= head;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(out_data) <= MAX_OUT) && (longint'(out_data) >= MIN_OUT));

endmodule

// File: tb/test_fir_mcm_top.sv
module test_fir_mcm_top;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 12;
    localparam int ACC_W      = DATA_W + 12;
    localparam int NT         = 5;
    localparam int COEF [NT]  = '{5, 261, 341, 261, 5};

    // table: valid, sample, expected output (R5 impulse, R3 step, R4 gap)
    localparam int VEC_N = 14;
    localparam int VEC_V [VEC_N] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 0, 1};
    localparam int VEC_X [VEC_N] = '{1, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1500, -1};
    localparam int VEC_Y [VEC_N] = '{5, 261, 341, 261, 5, 0, 5, 266, 607, 868, 873, 873, 873, 863};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DATA_W-1:0] in_data = '0;
    logic out_valid;
    logic signed [ACC_W-1:0] out_data;

    int errors = 0;
    int checks = 0;
    int hist [NT];
    int model_y = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fir_mcm_top #(.DATA_W(DATA_W)) i_fir_mcm_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < NT; k++) hist[k] = 0;
        model_y = 0;
    endtask

    // drive one cycle at the falling edge, check after the next rising edge
    task automatic push(input bit v, input int x);
        in_valid = v;
        in_data  = DATA_W'(x);
        if (v) begin
            for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = x;
            model_y = 0;
            for (int k = 0; k < NT; k++) model_y += COEF[k] * hist[k];
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 out_data in reset", int'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after release", int'(out_valid), 0);

        // vector table: impulse (R5), step (R3), gap with garbage (R4)
        for (int i = 0; i < VEC_N; i++) begin
            push(VEC_V[i] != 0, VEC_X[i]);
            check("R2 out_valid per table row", int'(out_valid), VEC_V[i]);
            check("R3/R5 table output", int'(out_data), VEC_Y[i]);
            check("R3 model agrees with table", model_y, VEC_Y[i]);
        end

        // R1: reset mid-stream clears the delay chain
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 out_data cleared by reset", int'(out_data), 0);
        rst_n = 1'b1;
        model_clear();
        push(1'b1, -3);
        check("R1 first output after reset", int'(out_data), -15);
        push(1'b1, 0);
        check("R1 no stale history", int'(out_data), -783);

        // R6: full-scale positive and negative runs
        model_clear();
        for (int i = 0; i < NT; i++) push(1'b1, 0);
        for (int i = 0; i < NT; i++) push(1'b1, 2047);
        check("R6 max positive output", int'(out_data), 1787031);
        for (int i = 0; i < NT; i++) push(1'b1, -2048);
        check("R6 max negative output", int'(out_data), -1787904);

        // R7: impulses of various amplitudes expose each shared product
        for (int i = 0; i < NT; i++) push(1'b1, 0);
        push(1'b1, -1234);
        check("R7 tap0 uses 5x", int'(out_data), -6170);
        push(1'b1, 0);
        check("R7 tap1 uses 261x", int'(out_data), -322074);
        push(1'b1, 0);
        check("R7 tap2 uses 341x", int'(out_data), -420794);

        // random stream with gaps carrying garbage (R3, R4)
        void'($urandom(32'd11));
        for (int i = 0; i < 400; i++) begin
            bit v;
            int x;
            v = ($urandom_range(3) != 0);
            x = int'($urandom_range(4095)) - 2048;
            push(v, x);
            check("R2 random out_valid", int'(out_valid), int'(v));
            check(v ? "R3 random output" : "R4 hold during gap", int'(out_data), model_y);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule